// File: doc/BRIEF.md
# Interleaved Scratchpad DMA Address Sequencer

This block produces the per-quadword address stream for a DMA transfer that runs in interleave mode between a 16 KB scratchpad and main memory. A start strobe captures five values: a total quadword count, a main-memory address, a scratchpad address, a burst length and a skip length. The block then issues one request per quadword. Each request carries both byte addresses and a direction flag. The data path consumes the requests under a valid/ready handshake.

Quadwords move in bursts. A burst holds the burst length or the quadwords still outstanding, whichever is smaller. A burst length of zero makes the whole transfer a single burst. After a burst, the main-memory pointer jumps past a gap of skip-length quadwords. The scratchpad pointer never skips and wraps inside the 16 KB space. A one-cycle done pulse follows the final accepted quadword.

Top module: `sdma_interleave_seq`

## Requirements
- R1: A start strobe seen while idle with a nonzero count makes `busy` and `req_valid` high in the next cycle, and `remaining_qwc` then equals the loaded count.
- R2: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_maddr` and `req_saddr` hold their values into the next cycle.
- R3: Inside a burst, each accepted quadword advances `req_maddr` by 16.
- R4: Bursts hold min(burst length, quadwords outstanding), with a burst length of 0 meaning the full count. `req_burst_end` is high on the last quadword of each burst.
- R5: The first quadword of each burst after the first has main address = previous burst's first address + (skip + previous burst size) × 16.
- R6: Each accepted quadword advances `req_saddr` by 16 modulo 16384. A run past offset 0x3FF0 continues at 0x0000.
- R7: Bits [3:0] of `req_maddr` and `req_saddr` are always zero, whatever the start inputs hold.
- R8: `remaining_qwc` falls by one on each accepted quadword and is zero when `done` is high.
- R9: `done` is high for exactly one cycle, the cycle after the last quadword is accepted. Exactly `total_qwc` quadwords are accepted per transfer.
- R10: A start strobe while `busy` is high is ignored, and the running transfer continues with its captured values.
- R11: A start with a count of zero issues no request and pulses `done` in the next cycle.
- R12: `req_dir` holds the `dir_in` value captured at start for the whole transfer (1 = scratchpad to main memory, 0 = main memory to scratchpad). Later changes of the start inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (used only while idle) |
| dir_in | input | 1 | Direction captured at start |
| total_qwc | input | CNT_W | Quadwords to move |
| main_addr | input | MA_W | Main-memory start byte address |
| spad_addr | input | SA_W | Scratchpad start byte address |
| burst_qwc | input | BLEN_W | Quadwords per burst, 0 = whole count |
| skip_qwc | input | BLEN_W | Quadwords skipped in main memory after each burst |
| req_valid | output | 1 | A quadword request is offered |
| req_ready | input | 1 | The consumer takes the request this cycle |
| req_dir | output | 1 | Captured direction |
| req_maddr | output | MA_W | Main-memory byte address of this quadword |
| req_saddr | output | SA_W | Scratchpad byte address of this quadword |
| req_burst_end | output | 1 | This quadword closes a burst |
| remaining_qwc | output | CNT_W | Quadwords not yet accepted |
| busy | output | 1 | A transfer or its done cycle is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two cases are hard to reach from the ports. The first is a second start strobe that lands mid-transfer. The bench raises it with new count and address values at the third quadword, then requires the original address stream and beat count to finish unchanged. The second is a burst boundary that meets the scratchpad wrap while the consumer stalls. For that case the bench sets the scratchpad start just below the 16 KB limit, uses short bursts with a nonzero skip, and throttles `req_ready` with a periodic pattern. Each accepted quadword is then compared against a stream the bench builds burst by burst.

// File: rtl/sdma_pkg.sv
// Shared types for the interleaved scratchpad DMA sequencer.
// Assumes byte addresses with 16-byte quadwords.
package sdma_pkg;
    localparam int QW_SHIFT = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } sdma_state_e;
endpackage

// File: rtl/sdma_beat_ctr.sv
// Counts the quadwords left in a transfer and the position inside the
// current burst, and flags the last beat of each burst and of the transfer.
// Assumes BLEN_W <= CNT_W and that step is only raised while beats remain.
module sdma_beat_ctr #(
    parameter int CNT_W  = 16,
    parameter int BLEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  total,
    input  logic [BLEN_W-1:0] blen,
    input  logic              step,
    output logic [CNT_W-1:0]  remaining,
    output logic              burst_end,
    output logic              last
);
    logic [CNT_W-1:0] rem_q;
    logic [CNT_W-1:0] eff_q;
    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] pos_inc;

    assign pos_inc   = pos_q + CNT_W'(1);
    assign last      = (rem_q == CNT_W'(1));
    assign burst_end = last || (pos_inc == eff_q);
    assign remaining = rem_q;

    // Capture the count and effective burst size, then track progress per beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            eff_q <= '0;
            pos_q <= '0;
        end else if (load) begin
            rem_q <= total;
            eff_q <= (blen == '0) ? total : CNT_W'(blen);
            pos_q <= '0;
        end else if (step) begin
            rem_q <= rem_q - CNT_W'(1);
            pos_q <= burst_end ? '0 : pos_inc;
        end
    end
endmodule

// File: rtl/sdma_addr_gen.sv
// Holds the main-memory and scratchpad quadword pointers. The scratchpad
// pointer wraps naturally at its width. The main pointer adds the skip
// length after a burst-closing beat. The low four address bits are forced
// to zero.
module sdma_addr_gen #(
    parameter int MA_W   = 32,
    parameter int SA_W   = 14,
    parameter int BLEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MA_W-1:0]   maddr_in,
    input  logic [SA_W-1:0]   saddr_in,
    input  logic [BLEN_W-1:0] skip_in,
    input  logic              step,
    input  logic              burst_end,
    output logic [MA_W-1:0]   maddr,
    output logic [SA_W-1:0]   saddr
);
    import sdma_pkg::*;

    localparam int MQ_W = MA_W - QW_SHIFT;
    localparam int SQ_W = SA_W - QW_SHIFT;

    logic [MQ_W-1:0]   mq_q;
    logic [SQ_W-1:0]   sq_q;
    logic [BLEN_W-1:0] skip_q;
    logic [MQ_W-1:0]   m_incr;

    assign m_incr = MQ_W'(1) + (burst_end ? MQ_W'(skip_q) : '0);
    assign maddr  = {mq_q, {QW_SHIFT{1'b0}}};
    assign saddr  = {sq_q, {QW_SHIFT{1'b0}}};

    // Load aligned pointers at start, advance both on every accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mq_q   <= '0;
            sq_q   <= '0;
            skip_q <= '0;
        end else if (load) begin
            mq_q   <= maddr_in[MA_W-1:QW_SHIFT];
            sq_q   <= saddr_in[SA_W-1:QW_SHIFT];
            skip_q <= skip_in;
        end else if (step) begin
            mq_q <= mq_q + m_incr;
            sq_q <= sq_q + SQ_W'(1);
        end
    end
endmodule

// File: rtl/sdma_interleave_seq.sv
// Top of the interleaved scratchpad DMA sequencer. A start strobe seen
// while idle captures the transfer. Requests then go out one quadword per
// cycle under valid/ready, and a one-cycle done pulse follows the last
// accepted beat. Assumes the consumer never drops a request it accepted.
module sdma_interleave_seq #(
    parameter int CNT_W  = 16,
    parameter int BLEN_W = 8,
    parameter int MA_W   = 32,
    parameter int SA_W   = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_in,
    input  logic [CNT_W-1:0]  total_qwc,
    input  logic [MA_W-1:0]   main_addr,
    input  logic [SA_W-1:0]   spad_addr,
    input  logic [BLEN_W-1:0] burst_qwc,
    input  logic [BLEN_W-1:0] skip_qwc,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_dir,
    output logic [MA_W-1:0]   req_maddr,
    output logic [SA_W-1:0]   req_saddr,
    output logic              req_burst_end,
    output logic [CNT_W-1:0]  remaining_qwc,
    output logic              busy,
    output logic              done
);
    import sdma_pkg::*;

    sdma_state_e state_q;
    logic        load;
    logic        accept;
    logic        last;
    logic        burst_end;
    logic        dir_q;

    assign load          = start && (state_q == ST_IDLE);
    assign req_valid     = (state_q == ST_RUN);
    assign accept        = req_valid && req_ready;
    assign busy          = (state_q != ST_IDLE);
    assign done          = (state_q == ST_FIN);
    assign req_dir       = dir_q;
    assign req_burst_end = burst_end;

    // Sequence idle -> run -> finish pulse -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (load) state_q <= (total_qwc == '0) ? ST_FIN : ST_RUN;
                ST_RUN:  if (accept && last) state_q <= ST_FIN;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the direction for the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)    dir_q <= 1'b0;
        else if (load) dir_q <= dir_in;
    end

    sdma_beat_ctr #(
        .CNT_W (CNT_W),
        .BLEN_W(BLEN_W)
    ) u_beats (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .total    (total_qwc),
        .blen     (burst_qwc),
        .step     (accept),
        .remaining(remaining_qwc),
        .burst_end(burst_end),
        .last     (last)
    );

    sdma_addr_gen #(
        .MA_W  (MA_W),
        .SA_W  (SA_W),
        .BLEN_W(BLEN_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .maddr_in (main_addr),
        .saddr_in (spad_addr),
        .skip_in  (skip_qwc),
        .step     (accept),
        .burst_end(burst_end),
        .maddr    (req_maddr),
        .saddr    (req_saddr)
    );
endmodule

// File: rtl/sdma_chk.sv
// Protocol and sequencing checks for the sequencer, observed at its ports.
// Bound to every instance of the top module.
module sdma_chk #(
    parameter int CNT_W = 16,
    parameter int MA_W  = 32,
    parameter int SA_W  = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_dir,
    input logic [MA_W-1:0]  req_maddr,
    input logic [SA_W-1:0]  req_saddr,
    input logic             req_burst_end,
    input logic [CNT_W-1:0] remaining_qwc,
    input logic             done
);
    a_r2_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_maddr) && $stable(req_saddr));

    a_r7_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_maddr[3:0] == 4'd0) && (req_saddr[3:0] == 4'd0));

    a_r6_spad_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_ready) && req_valid
            |-> (req_saddr - $past(req_saddr)) == SA_W'(16));

    a_r3_main_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_ready && !req_burst_end) && req_valid
            |-> (req_maddr - $past(req_maddr)) == MA_W'(16));

    a_r8_zero_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> remaining_qwc == '0);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_no_req_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid);

    a_r12_dir_steady: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && $past(req_valid) |-> $stable(req_dir));
endmodule

bind sdma_interleave_seq sdma_chk #(
    .CNT_W(CNT_W),
    .MA_W (MA_W),
    .SA_W (SA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_dir      (req_dir),
    .req_maddr    (req_maddr),
    .req_saddr    (req_saddr),
    .req_burst_end(req_burst_end),
    .remaining_qwc(remaining_qwc),
    .done         (done)
);

// File: tb/test_sdma_interleave_seq.sv
// Directed bench: one task per scenario, expected streams built per burst.
module test_sdma_interleave_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_in = 1'b0;
    logic [15:0] total_qwc = '0;
    logic [31:0] main_addr = '0;
    logic [13:0] spad_addr = '0;
    logic [7:0]  burst_qwc = '0;
    logic [7:0]  skip_qwc = '0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic        req_dir;
    logic [31:0] req_maddr;
    logic [13:0] req_saddr;
    logic        req_burst_end;
    logic [15:0] remaining_qwc;
    logic        busy;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [31:0] exp_m [256];
    logic [13:0] exp_s [256];
    logic        exp_e [256];

    always #10 clk = ~clk;

    sdma_interleave_seq i_sdma_interleave_seq (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Runs one transfer and compares every accepted beat with the burst model.
    task automatic run_xfer(input int cnt, input logic [31:0] ma, input logic [13:0] sa,
                            input int bl, input int sk, input logic d,
                            input int stall_mod, input bit inject, input string tag);
        int eff, rem, bq, n, idx, guard;
        logic [31:0] bs;
        logic [13:0] s;
        bit fired;
        eff = (bl == 0) ? cnt : bl;
        rem = cnt; bs = ma & ~32'hF; s = sa & ~14'hF; n = 0;
        while (rem > 0) begin
            bq = (eff < rem) ? eff : rem;
            for (int j = 0; j < bq; j++) begin
                exp_m[n] = bs + 32'(16 * j);
                exp_s[n] = s;
                s = s + 14'd16;
                exp_e[n] = (j == bq - 1);
                n++;
            end
            bs = bs + 32'((sk + bq) * 16);
            rem = rem - bq;
        end
        @(negedge clk);
        start = 1'b1; dir_in = d; total_qwc = 16'(cnt); main_addr = ma;
        spad_addr = sa; burst_qwc = 8'(bl); skip_qwc = 8'(sk);
        @(negedge clk);
        start = 1'b0; dir_in = ~d; total_qwc = 16'd99; main_addr = 32'hDEAD_BEE0;
        spad_addr = 14'h0100; burst_qwc = 8'd1; skip_qwc = 8'd7;
        #1;
        if (cnt == 0) begin
            check(done == 1'b1, {tag, " R11 done after zero start"}, done, 1);
            check(req_valid == 1'b0, {tag, " R11 no request"}, req_valid, 0);
            @(negedge clk);
            check(done == 1'b0, {tag, " R11 done one cycle"}, done, 0);
            return;
        end
        check(busy && req_valid, {tag, " R1 busy and valid after start"}, {busy, req_valid}, 3);
        check(remaining_qwc == 16'(cnt), {tag, " R1 count loaded"}, remaining_qwc, cnt);
        idx = 0; guard = 0; fired = 0;
        while (idx < cnt && guard < 4000) begin
            if (guard > 0) @(negedge clk);
            start = 1'b0;
            if (inject && !fired && idx == 2) begin
                start = 1'b1; total_qwc = 16'd3; main_addr = 32'h0000_8000; fired = 1;
            end
            req_ready = (stall_mod == 0) || ((guard % stall_mod) != 0);
            #1;
            if (!req_valid) begin
                check(0, {tag, " R9 valid dropped early"}, idx, cnt);
                break;
            end
            if (req_ready) begin
                check(req_maddr == exp_m[idx], {tag, " R3/R5 main address"}, req_maddr, exp_m[idx]);
                check(req_saddr == exp_s[idx], {tag, " R6 spad address"}, req_saddr, exp_s[idx]);
                check(req_burst_end == exp_e[idx], {tag, " R4 burst end"}, req_burst_end, exp_e[idx]);
                check(req_dir == d, {tag, " R12 dir"}, req_dir, d);
                check(remaining_qwc == 16'(cnt - idx), {tag, " R8 remaining"}, remaining_qwc, cnt - idx);
                check(req_maddr[3:0] == 0 && req_saddr[3:0] == 0, {tag, " R7 aligned"},
                      {req_maddr[3:0], req_saddr[3:0]}, 0);
                idx++;
            end
            guard++;
        end
        if (guard >= 4000) check(0, {tag, " R9 transfer hung"}, idx, cnt);
        @(negedge clk);
        start = 1'b0; req_ready = 1'b0;
        #1;
        check(done == 1'b1, {tag, " R9 done after last beat"}, done, 1);
        check(remaining_qwc == 0, {tag, " R8 zero at done"}, remaining_qwc, 0);
        check(req_valid == 1'b0, {tag, " R9 no extra beat"}, req_valid, 0);
        @(negedge clk);
        #1;
        check(done == 1'b0 && busy == 1'b0, {tag, " R9/R10 idle after pulse"}, {done, busy}, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        check(!req_valid && !done && !busy, "R1 reset idle", {req_valid, done, busy}, 0);
        check(remaining_qwc == 0, "R8 reset remaining", remaining_qwc, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_xfer(10, 32'h0010_0000, 14'h0200, 4, 2, 1'b0, 0, 0, "bursts4_skip2");
        run_xfer(7,  32'h0020_0040, 14'h0000, 0, 5, 1'b1, 0, 0, "R4 zero_burst");
        run_xfer(6,  32'h0000_1000, 14'h3FE0, 3, 1, 1'b0, 0, 0, "R6 spad_wrap");
        run_xfer(9,  32'h0000_2000, 14'h3FD0, 2, 3, 1'b1, 3, 0, "R2 stalled_wrap");
        run_xfer(5,  32'h0000_300F, 14'h012B, 2, 0, 1'b0, 0, 0, "R7 unaligned");
        run_xfer(8,  32'h0004_0000, 14'h0400, 3, 4, 1'b1, 2, 1, "R10 start_busy");
        run_xfer(0,  32'h0000_5000, 14'h0500, 2, 1, 1'b0, 0, 0, "R11 zero_count");
        run_xfer(1,  32'h0000_6000, 14'h3FF0, 1, 9, 1'b1, 0, 0, "R5 single");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule